// File: doc/BRIEF.md
# Receiver-Enable Delay Sweep Controller

This block sequences receiver-enable training for one rank of a memory channel with eight byte lanes. After a start pulse it walks a shared delay code upward from zero. At each code it makes two test rounds. Before each round it drives the code to every lane. Each round is one request to an external memory-test engine, which writes a pattern, reads it back, compares it and answers with an 8-bit map of the lanes that passed. The two rounds use two pattern/address pairs. The second address sits a fixed page offset above the first. The order of the pairs alternates from one code to the next.

The two per-round maps of a step are ANDed together. A lane tracker keeps, for each lane, the code at which that lane started passing, plus an offset of 0x20. The sweep stops at the first code where all eight lanes pass. If no code up to 0xFE gets every lane through, the sweep ends with an error and the code parked at 0xFF. In both cases the block leaves training mode and presents a maximum-latency value equal to the final code plus 0x20.

Top module: `rxen_sweep_ctrl`

## Requirements
- R1: A start pulse while not training clears done and error and raises the training-mode output. Training mode falls when the sweep ends, and done (plus error, if set) stays high until the next start. A start pulse during training is ignored.
- R2: The delay code begins at 0 and rises by exactly one per step. In the cycle before every test request, the code is driven to all lanes with a one-cycle write strobe.
- R3: Each step makes exactly two test requests. The step result is the bitwise AND of the two returned lane maps; bit i of the map is lane i, and 1 means the lane passed.
- R4: The pair index of a round is the round number (0 or 1) XOR bit 0 of the code. The index appears on the select output. Pair 0 uses the base address and pair 1 uses the base address plus the page offset.
- R5: A request stays high until acknowledge is sampled with it, and no second request is raised before the first is acknowledged.
- R6: A lane that passes a step, and did not pass the step before, captures the code plus 0x20 (8 bits, lane i at bits 8i+7..8i of the lane delay output). The lane mask output equals the latest step result.
- R7: The sweep ends after the first step whose result is all ones.
- R8: If the step at code 0xFE fails, the error output rises, the code reads 0xFF and the maximum latency reads 0x11F.
- R9: At the end of the sweep the 9-bit maximum latency equals the final code plus 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| base_addr_i | input | ADDR_W | Address of pattern pair 0 |
| train_mode_o | output | 1 | High while training runs |
| dly_code_o | output | 8 | Delay code driven to all lanes |
| dly_wr_o | output | 1 | Strobe applying the code to all lanes |
| test_req_o | output | 1 | Memory-test request |
| test_addr_o | output | ADDR_W | Address for the current round |
| test_sel_o | output | 1 | Pattern pair index for the current round |
| test_ack_i | input | 1 | Request acknowledge |
| test_pass_i | input | 8 | Lane pass map, valid with acknowledge |
| lane_mask_o | output | 8 | Lanes that passed the latest step |
| lane_dly_o | output | 64 | Captured delay per lane |
| max_lat_o | output | 9 | Final code plus 0x20 |
| done_o | output | 1 | Sweep finished |
| err_o | output | 1 | No passing window found |

## Verification
The assertions assume that the test engine raises acknowledge only while a request is pending, for one cycle, with the pass map valid in that same cycle, and that start arrives as a single-cycle pulse. The bench answers each request after a latency of zero to two idle cycles, holds acknowledge for exactly one cycle, and then drops it at once. It builds each lane map from per-lane passing windows, plus a failure tied to one pattern pair. It fires a spurious start only while training is running.

// File: rtl/rxen_pkg.sv
package rxen_pkg;

    localparam int LANES   = 8;
    localparam int CODE_W  = 8;
    localparam int LAT_W   = CODE_W + 1;
    localparam logic [CODE_W-1:0] LAST_CODE = 8'hFE;
    localparam logic [CODE_W-1:0] STOP_CODE = 8'hFF;
    localparam logic [LAT_W-1:0]  LAT_OFS   = 9'h020;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETDLY,
        ST_TEST,
        ST_EVAL
    } sweep_st_t;

    function automatic logic pair_of(input logic round, input logic code_lsb);
        return round ^ code_lsb;
    endfunction

    function automatic logic [LAT_W-1:0] lat_of(input logic [CODE_W-1:0] code);
        return {1'b0, code} + LAT_OFS;
    endfunction

endpackage

// File: rtl/rxen_pair_addr.sv
module rxen_pair_addr #(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] PAGE_OFS = 32'h0010_0000
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic              sel_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int NPAIR = 2;

    logic [ADDR_W-1:0] pair_addr [NPAIR];

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign pair_addr[p] = base_i + ADDR_W'(p) * ADDR_W'(PAGE_OFS);
    end

    assign addr_o = pair_addr[sel_i];
endmodule

// File: rtl/rxen_lane_tracker.sv
module rxen_lane_tracker #(
    parameter int LANES  = rxen_pkg::LANES,
    parameter int CODE_W = rxen_pkg::CODE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr_i,
    input  logic                     upd_i,
    input  logic [LANES-1:0]         pass_i,
    input  logic [CODE_W-1:0]        code_i,
    output logic [LANES-1:0]         mask_o,
    output logic [LANES*CODE_W-1:0]  dly_o,
    output logic                     all_o
);
    localparam logic [CODE_W-1:0] OFS = CODE_W'(rxen_pkg::LAT_OFS);

    logic [LANES-1:0] seen_q;
    logic [LANES-1:0] seen_d;
    logic [LANES-1:0] fresh;

    // a lane kept from the last step stays; a new pass is captured
    assign seen_d = (seen_q & pass_i) | pass_i;
    assign fresh  = pass_i & ~(seen_q & pass_i);
    assign all_o  = &seen_d;
    assign mask_o = seen_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            seen_q <= '0;
        else if (upd_i)
            seen_q <= seen_d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [CODE_W-1:0] cap_q;
        always_ff @(posedge clk) begin
            if (rst)
                cap_q <= '0;
            else if (upd_i && fresh[g])
                cap_q <= code_i + OFS;
        end
        assign dly_o[g*CODE_W +: CODE_W] = cap_q;
    end

    AST_MASK_FROM_STEP: assert property (@(posedge clk) disable iff (rst)
        (upd_i && !clr_i) |=> (mask_o & ~$past(pass_i)) == '0); // R6
endmodule

// File: rtl/rxen_sweep_ctrl.sv
module rxen_sweep_ctrl
    import rxen_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] PAGE_OFS = 32'h0010_0000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [ADDR_W-1:0]       base_addr_i,
    output logic                    train_mode_o,
    output logic [CODE_W-1:0]       dly_code_o,
    output logic                    dly_wr_o,
    output logic                    test_req_o,
    output logic [ADDR_W-1:0]       test_addr_o,
    output logic                    test_sel_o,
    input  logic                    test_ack_i,
    input  logic [LANES-1:0]        test_pass_i,
    output logic [LANES-1:0]        lane_mask_o,
    output logic [LANES*CODE_W-1:0] lane_dly_o,
    output logic [LAT_W-1:0]        max_lat_o,
    output logic                    done_o,
    output logic                    err_o
);
    sweep_st_t         st_q;
    logic [CODE_W-1:0] code_q;
    logic              round_q;
    logic [LANES-1:0]  acc_q;
    logic              train_q;
    logic              done_q;
    logic              err_q;
    logic [LAT_W-1:0]  lat_q;
    logic              launch;
    logic              all_pass;

    assign launch = (st_q == ST_IDLE) && start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            code_q  <= '0;
            round_q <= 1'b0;
            acc_q   <= '1;
            train_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            lat_q   <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start_i) begin
                    code_q  <= '0;
                    round_q <= 1'b0;
                    acc_q   <= '1;
                    train_q <= 1'b1;
                    done_q  <= 1'b0;
                    err_q   <= 1'b0;
                    st_q    <= ST_SETDLY;
                end
                ST_SETDLY: st_q <= ST_TEST;
                ST_TEST: if (test_ack_i) begin
                    acc_q <= acc_q & test_pass_i;
                    if (!round_q) begin
                        round_q <= 1'b1;
                        st_q    <= ST_SETDLY;
                    end else begin
                        st_q    <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (all_pass) begin
                        train_q <= 1'b0;
                        done_q  <= 1'b1;
                        lat_q   <= lat_of(code_q);
                        st_q    <= ST_IDLE;
                    end else if (code_q == LAST_CODE) begin
                        code_q  <= STOP_CODE;
                        train_q <= 1'b0;
                        done_q  <= 1'b1;
                        err_q   <= 1'b1;
                        lat_q   <= lat_of(STOP_CODE);
                        st_q    <= ST_IDLE;
                    end else begin
                        code_q  <= code_q + 8'd1;
                        round_q <= 1'b0;
                        acc_q   <= '1;
                        st_q    <= ST_SETDLY;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    rxen_lane_tracker #(.LANES(LANES), .CODE_W(CODE_W)) u_track (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (launch),
        .upd_i  (st_q == ST_EVAL),
        .pass_i (acc_q),
        .code_i (code_q),
        .mask_o (lane_mask_o),
        .dly_o  (lane_dly_o),
        .all_o  (all_pass)
    );

    rxen_pair_addr #(.ADDR_W(ADDR_W), .PAGE_OFS(PAGE_OFS)) u_addr (
        .base_i (base_addr_i),
        .sel_i  (test_sel_o),
        .addr_o (test_addr_o)
    );

    assign test_sel_o   = pair_of(round_q, code_q[0]);
    assign test_req_o   = (st_q == ST_TEST);
    assign dly_wr_o     = (st_q == ST_SETDLY);
    assign dly_code_o   = code_q;
    assign train_mode_o = train_q;
    assign done_o       = done_q;
    assign err_o        = err_q;
    assign max_lat_o    = lat_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (test_req_o && !test_ack_i) |=> test_req_o); // R5
    AST_WR_BEFORE_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(test_req_o) |-> $past(dly_wr_o)); // R2
    AST_CODE_STEP: assert property (@(posedge clk) disable iff (rst)
        (train_mode_o && $past(train_mode_o) && dly_code_o != $past(dly_code_o))
        |-> dly_code_o == $past(dly_code_o) + 8'd1); // R2
    AST_ERR_PARK: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (dly_code_o == 8'hFF && max_lat_o == 9'h11F)); // R8
    AST_FINAL_LAT: assert property (@(posedge clk) disable iff (rst)
        done_o |-> max_lat_o == {1'b0, dly_code_o} + 9'h020); // R9
    AST_QUIET_DONE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!train_mode_o && !test_req_o)); // R1
endmodule

// File: tb/rxen_sweep_ctrl_bench.sv
module rxen_sweep_ctrl_bench;
    localparam int          AW   = 32;
    localparam logic [31:0] PAGE = 32'h0010_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_addr_i = '0;
    logic          train_mode_o, dly_wr_o, test_req_o, test_sel_o;
    logic [7:0]    dly_code_o;
    logic [AW-1:0] test_addr_o;
    logic          test_ack_i = 1'b0;
    logic [7:0]    test_pass_i = '0;
    logic [7:0]    lane_mask_o;
    logic [63:0]   lane_dly_o;
    logic [8:0]    max_lat_o;
    logic          done_o, err_o;

    always #2 clk = ~clk;

    rxen_sweep_ctrl #(.ADDR_W(AW), .PAGE_OFS(PAGE)) u_rxen_sweep_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .base_addr_i(base_addr_i),
        .train_mode_o(train_mode_o), .dly_code_o(dly_code_o), .dly_wr_o(dly_wr_o),
        .test_req_o(test_req_o), .test_addr_o(test_addr_o), .test_sel_o(test_sel_o),
        .test_ack_i(test_ack_i), .test_pass_i(test_pass_i),
        .lane_mask_o(lane_mask_o), .lane_dly_o(lane_dly_o), .max_lat_o(max_lat_o),
        .done_o(done_o), .err_o(err_o));

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit wd = 1'b0;

    int lo [8];
    int hi [8];
    int bad1 [8];
    int glitch [8];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !wd) begin
            wd = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
        end
    end

    function automatic bit lane_ok(int ln, int code, int pair);
        if (code == glitch[ln]) return 1'b1;
        if (code < lo[ln] || code > hi[ln]) return 1'b0;
        if (pair == 1 && code == bad1[ln]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [7:0] map_of(int code, int pair);
        logic [7:0] m;
        for (int l = 0; l < 8; l++) m[l] = lane_ok(l, code, pair);
        return m;
    endfunction

    task automatic run_sweep(input logic [AW-1:0] base, input int stray_at);
        logic [7:0] prev;
        logic [7:0] acc;
        logic [7:0] exp_dly [8];
        int   exp_code;
        bit   exp_err;
        int   c;
        int   r;
        int   nreq;
        bit   last_wr;
        int   lat;
        logic pair;

        prev = '0;
        exp_err = 1'b1;
        exp_code = 255;
        for (int l = 0; l < 8; l++) exp_dly[l] = '0;
        for (int k = 0; k < 255; k++) begin
            acc = map_of(k, 0) & map_of(k, 1);
            for (int l = 0; l < 8; l++)
                if (acc[l] && !prev[l]) exp_dly[l] = 8'(k + 32);
            prev = acc;
            if (acc == 8'hFF) begin
                exp_code = k;
                exp_err = 1'b0;
                break;
            end
        end

        base_addr_i = base;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1 training mode after start", 64'(train_mode_o), 64'd1);
        chk("R1 done cleared by start", 64'(done_o), 64'd0);
        chk("R1 error cleared by start", 64'(err_o), 64'd0);
        last_wr = dly_wr_o;
        c = 0;
        r = 0;
        nreq = 0;
        while (!done_o && !wd) begin
            @(negedge clk);
            if (test_req_o) begin
                pair = 1'(r) ^ 1'(c);
                chk("R2 code at request", 64'(dly_code_o), 64'(c));
                chk("R2 lane write strobe before request", 64'(last_wr), 64'd1);
                chk("R4 pair select", 64'(test_sel_o), 64'(pair));
                chk("R4 test address", 64'(test_addr_o), 64'(base + (pair ? PAGE : 32'd0)));
                chk("R1 training mode during sweep", 64'(train_mode_o), 64'd1);
                nreq++;
                if (nreq == stray_at) start_i = 1'b1;
                lat = (c + r) % 3;
                for (int w = 0; w < lat; w++) begin
                    @(negedge clk);
                    start_i = 1'b0;
                    chk("R5 request held until acknowledge", 64'(test_req_o), 64'd1);
                end
                test_ack_i = 1'b1;
                test_pass_i = map_of(c, int'(pair));
                @(negedge clk);
                start_i = 1'b0;
                test_ack_i = 1'b0;
                test_pass_i = '0;
                chk("R5 request drops after acknowledge", 64'(test_req_o), 64'd0);
                last_wr = dly_wr_o;
                if (r == 1) begin
                    r = 0;
                    c++;
                end else begin
                    r = 1;
                end
            end else begin
                last_wr = dly_wr_o;
            end
        end
        chk("R3 two requests per step", 64'(nreq), 64'(2 * (exp_code < 255 ? exp_code + 1 : 255)));
        chk("R7/R8 final code", 64'(dly_code_o), 64'(exp_code));
        chk("R8 error flag", 64'(err_o), 64'(exp_err));
        chk("R9 max latency", 64'(max_lat_o), 64'(exp_code + 32));
        chk("R6 lane mask", 64'(lane_mask_o), 64'(prev));
        for (int l = 0; l < 8; l++)
            if (prev[l]) chk("R6 lane delay", 64'(lane_dly_o[l*8 +: 8]), 64'(exp_dly[l]));
        chk("R1 training mode cleared", 64'(train_mode_o), 64'd0);
        repeat (4) @(negedge clk);
        chk("R1 done held", 64'(done_o), 64'd1);
        chk("R1 error held", 64'(err_o), 64'(exp_err));
        chk("R7 no request after end", 64'(test_req_o), 64'd0);
    endtask

    task automatic set_all(input int l0, input int h0);
        for (int l = 0; l < 8; l++) begin
            lo[l] = l0; hi[l] = h0; bad1[l] = -1; glitch[l] = -1;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset training mode", 64'(train_mode_o), 64'd0);
        chk("R1 reset done", 64'(done_o), 64'd0);
        chk("R1 reset error", 64'(err_o), 64'd0);
        chk("R5 reset request", 64'(test_req_o), 64'd0);

        // all lanes pass at code 0
        set_all(0, 255);
        run_sweep(32'h0000_4000, 0);

        // staggered lane windows, stray start mid-sweep
        set_all(0, 255);
        for (int l = 0; l < 8; l++) lo[l] = 2 + 3 * l;
        run_sweep(32'h0123_0000, 7);

        // lane 3 passes once early, then is recaptured; lane 0 fails only on pair 1
        set_all(4, 255);
        glitch[3] = 1;
        lo[3] = 9;
        bad1[0] = 6;
        lo[5] = 7;
        run_sweep(32'h8000_0000, 0);

        // lane 7 never passes: no passing window
        set_all(10, 255);
        lo[7] = 300;
        run_sweep(32'h0000_0040, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule